// File: doc/BRIEF.md
# Dual Process Queue Scheduler

This block keeps the program counters of two competing programs in a small shared machine. Each program owns a queue of process addresses. The scheduler takes turns between the two programs in a fixed order. On each turn it removes the oldest address from that program's queue and hands it to the execution core as the current PC, together with a tag that names the side. It then waits for the core to report completion. With the completion the core can return nothing, which kills the process. It can return one continuing address, or a continuing address plus a spawned address. The scheduler appends whatever comes back to the tail of the same queue.

At reset each queue is seeded with one entry-point address from the loader. Every address is reduced modulo the core size before it is stored. When one program has no processes left, the scheduler stops issuing. It then raises a game-over flag and names the losing side.

Top module: `pq_sched`

## Requirements
- R1: While reset is high, issue_valid and game_over are low and both q_empty bits are 1. After reset, side 0's reduced entry address is issued first, followed by side 1's.
- R2: While neither queue is empty, successive issues alternate strictly between side 0 and side 1.
- R3: The issued PC is the oldest address still held in the queue of the issued side.
- R4: An address returned with push_next on completion is placed at the back of the issued side's queue.
- R5: A completion with neither push_next nor push_spawn removes the process. Nothing is enqueued for it.
- R6: When push_next and push_spawn are both given, the next address is enqueued before the spawned address.
- R7: A spawned address is dropped when the queue is full after the next address has been enqueued.
- R8: Every stored address (entry, next, spawn) equals its input value modulo CORE_SIZE. An issued PC is always below CORE_SIZE.
- R9: q_full[s] is 1 exactly when queue s holds DEPTH addresses. q_empty[s] is 1 exactly when it holds none. Both are read while an issue is outstanding.
- R10: When a queue becomes empty, game_over rises with loser equal to that side. No further issue occurs, and game_over stays high until reset.
- R11: issue_valid, issue_pc and issue_side hold steady from issue until the cycle in which done is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry0 | input | ADDR_W | Entry-point address for side 0, sampled in the first cycle after reset |
| entry1 | input | ADDR_W | Entry-point address for side 1, sampled in the first cycle after reset |
| done | input | 1 | Core completion of the outstanding issue |
| push_next | input | 1 | With done: enqueue next_pc |
| next_pc | input | ADDR_W | Continuing address |
| push_spawn | input | 1 | With done: enqueue spawn_pc after next_pc |
| spawn_pc | input | ADDR_W | Spawned process address |
| issue_valid | output | 1 | An issued PC awaits completion |
| issue_pc | output | ADDR_W | Current PC |
| issue_side | output | 1 | Side that owns the current PC |
| q_full | output | 2 | Per-side queue full |
| q_empty | output | 2 | Per-side queue empty |
| game_over | output | 1 | A side has run out of processes |
| loser | output | 1 | Side whose queue emptied |

## Verification
The assertions assume that the core raises done only while issue_valid is high. They also assume that push_next and push_spawn carry meaning only in the cycle when done is sampled. The bench keeps to this rule: it waits for issue_valid, holds the issue for a random number of cycles, and then pulses done for exactly one cycle with random push choices and raw addresses across the whole ADDR_W range. Directed games cover out-of-range entry addresses, an immediate kill, and continuous spawning into a full queue.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_SEL,
    ST_LOAD,
    ST_RUN,
    ST_PUSH1,
    ST_PUSH2,
    ST_OVER
  } sched_st_t;
endpackage

// File: rtl/pq_wrap.sv
module pq_wrap #(
  parameter int CORE_SIZE = 8000,
  parameter int ADDR_W    = $clog2(CORE_SIZE)
) (
  input  logic [ADDR_W-1:0] raw,
  output logic [ADDR_W-1:0] red
);
  // One conditional subtract suffices since 2**ADDR_W < 2*CORE_SIZE.
  generate
    if (CORE_SIZE == (1 << ADDR_W)) begin : g_pow2
      assign red = raw;
    end else begin : g_sub
      localparam logic [ADDR_W-1:0] CS = ADDR_W'(CORE_SIZE);
      assign red = (raw >= CS) ? raw - CS : raw;
    end
  endgenerate
endmodule

// File: rtl/pq_fifo.sv
module pq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             wr_ok, rd_ok;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pq_sched.sv
module pq_sched #(
  parameter int CORE_SIZE = 8000,
  parameter int DEPTH     = 64,
  parameter int ADDR_W    = $clog2(CORE_SIZE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] entry0,
  input  logic [ADDR_W-1:0] entry1,
  input  logic              done,
  input  logic              push_next,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              push_spawn,
  input  logic [ADDR_W-1:0] spawn_pc,
  output logic              issue_valid,
  output logic [ADDR_W-1:0] issue_pc,
  output logic              issue_side,
  output logic [1:0]        q_full,
  output logic [1:0]        q_empty,
  output logic              game_over,
  output logic              loser
);
  import pq_pkg::*;

  localparam int NSIDE = 2;
  localparam int NRAW  = 4;

  sched_st_t         st;
  logic              turn;
  logic [ADDR_W-1:0] nxt_q, spn_q;
  logic              nxt_v, spn_v;
  logic              any_empty;

  logic [ADDR_W-1:0] raw_in  [NRAW];
  logic [ADDR_W-1:0] red_out [NRAW];

  logic [NSIDE-1:0]  wr_en, rd_en;
  logic [ADDR_W-1:0] wr_data [NSIDE];
  logic [ADDR_W-1:0] rd_data [NSIDE];

  assign raw_in[0] = entry0;
  assign raw_in[1] = entry1;
  assign raw_in[2] = next_pc;
  assign raw_in[3] = spawn_pc;

  generate
    for (genvar k = 0; k < NRAW; k++) begin : g_wrap
      pq_wrap #(.CORE_SIZE(CORE_SIZE), .ADDR_W(ADDR_W)) wrap_i (
        .raw (raw_in[k]),
        .red (red_out[k])
      );
    end
  endgenerate

  assign any_empty = |q_empty;

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      localparam logic SIDE = 1'(s);
      always_comb begin
        rd_en[s] = (st == ST_SEL) && (turn == SIDE) && !any_empty;
        wr_en[s] = (st == ST_INIT)
                || ((st == ST_PUSH1) && (turn == SIDE) && nxt_v)
                || ((st == ST_PUSH2) && (turn == SIDE) && spn_v);
        if (st == ST_INIT)       wr_data[s] = red_out[s];
        else if (st == ST_PUSH1) wr_data[s] = nxt_q;
        else                     wr_data[s] = spn_q;
      end

      // A full queue ignores the write: this drops a spawn that has no room.
      pq_fifo #(.DEPTH(DEPTH), .W(ADDR_W)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en[s]),
        .wr_data (wr_data[s]),
        .rd_en   (rd_en[s]),
        .rd_data (rd_data[s]),
        .full    (q_full[s]),
        .empty   (q_empty[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_INIT;
      turn        <= 1'b0;
      issue_valid <= 1'b0;
      issue_pc    <= '0;
      issue_side  <= 1'b0;
      game_over   <= 1'b0;
      loser       <= 1'b0;
      nxt_q       <= '0;
      spn_q       <= '0;
      nxt_v       <= 1'b0;
      spn_v       <= 1'b0;
    end else begin
      case (st)
        ST_INIT: st <= ST_SEL;
        ST_SEL: begin
          if (any_empty) begin
            game_over <= 1'b1;
            loser     <= ~q_empty[0];
            st        <= ST_OVER;
          end else begin
            st <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          issue_valid <= 1'b1;
          issue_pc    <= rd_data[turn];
          issue_side  <= turn;
          st          <= ST_RUN;
        end
        ST_RUN: begin
          if (done) begin
            issue_valid <= 1'b0;
            nxt_v       <= push_next;
            spn_v       <= push_spawn;
            nxt_q       <= red_out[2];
            spn_q       <= red_out[3];
            st          <= ST_PUSH1;
          end
        end
        ST_PUSH1: st <= ST_PUSH2;
        ST_PUSH2: begin
          turn <= ~turn;
          st   <= ST_SEL;
        end
        default: st <= ST_OVER;
      endcase
    end
  end
endmodule

// File: rtl/pq_sched_chk.sv
module pq_sched_chk #(
  parameter int CORE_SIZE = 8000,
  parameter int ADDR_W    = $clog2(CORE_SIZE)
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              issue_valid,
  input logic [ADDR_W-1:0] issue_pc,
  input logic              issue_side,
  input logic [1:0]        q_full,
  input logic [1:0]        q_empty,
  input logic              game_over,
  input logic              loser
);
  logic iv_d, has_prev, prev_side;

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_d      <= 1'b0;
      has_prev  <= 1'b0;
      prev_side <= 1'b0;
    end else begin
      iv_d <= issue_valid;
      if (issue_valid && !iv_d) begin
        has_prev  <= 1'b1;
        prev_side <= issue_side;
      end
    end
  end

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !done) |=> (issue_valid && $stable(issue_pc) && $stable(issue_side))); // R11
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !iv_d && has_prev) |-> (issue_side != prev_side)); // R2
  AST_PC_RANGE: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_pc < ADDR_W'(CORE_SIZE))); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    (q_full & q_empty) == 2'b00); // R9
  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (rst)
    game_over |=> game_over); // R10
  AST_OVER_QUIET: assert property (@(posedge clk) disable iff (rst)
    game_over |-> !issue_valid); // R10
  AST_OVER_LOSER: assert property (@(posedge clk) disable iff (rst)
    game_over |-> q_empty[loser]); // R10
endmodule

bind pq_sched pq_sched_chk #(.CORE_SIZE(CORE_SIZE), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .done        (done),
  .issue_valid (issue_valid),
  .issue_pc    (issue_pc),
  .issue_side  (issue_side),
  .q_full      (q_full),
  .q_empty     (q_empty),
  .game_over   (game_over),
  .loser       (loser)
);

// File: tb/pq_sched_tb_top.sv
module pq_sched_tb_top;
  localparam int CS = 8000;
  localparam int D  = 4;
  localparam int AW = $clog2(CS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] entry0 = '0, entry1 = '0;
  logic          done = 1'b0, push_next = 1'b0, push_spawn = 1'b0;
  logic [AW-1:0] next_pc = '0, spawn_pc = '0;
  logic          issue_valid, issue_side, game_over, loser;
  logic [AW-1:0] issue_pc;
  logic [1:0]    q_full, q_empty;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int mq [2][D];
  int hd [2];
  int cnt [2];

  always #4 clk = ~clk;

  pq_sched #(.CORE_SIZE(CS), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .entry0(entry0), .entry1(entry1),
    .done(done), .push_next(push_next), .next_pc(next_pc),
    .push_spawn(push_spawn), .spawn_pc(spawn_pc),
    .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_side(issue_side),
    .q_full(q_full), .q_empty(q_empty), .game_over(game_over), .loser(loser)
  );

  function automatic int wrapv(int v);
    return v % CS;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mpush(input int s, input int v);
    mq[s][(hd[s] + cnt[s]) % D] = v;
    cnt[s]++;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // mode 0: random, 1: kill at once, 2: spawn every turn
  task automatic play(input int e0, input int e1, input int mode);
    int last_side;
    bit over_exp;
    int lose_exp;
    rst = 1'b1;
    entry0 = AW'(e0);
    entry1 = AW'(e1);
    repeat (3) @(negedge clk);
    chk(!issue_valid && !game_over && q_empty == 2'b11, "R1 reset state",
        {issue_valid, game_over, q_empty}, 3);
    rst = 1'b0;
    hd = '{0, 0};
    cnt = '{0, 0};
    mpush(0, wrapv(e0));
    mpush(1, wrapv(e1));
    last_side = 1;
    over_exp = 1'b0;
    lose_exp = 0;
    for (int step = 0; step < 300; step++) begin
      int s, exp_pc, w, r, nv, sv;
      bit dn, ds;
      w = 0;
      while (!issue_valid && !game_over && w < 40) begin
        @(negedge clk);
        w++;
      end
      if (over_exp) begin
        chk(game_over == 1'b1, "R10 game_over raised", game_over, 1);
        chk(loser == lose_exp[0], "R10 loser side", loser, lose_exp);
        repeat (4) @(negedge clk);
        chk(!issue_valid && game_over, "R10 no issue after over",
            {issue_valid, game_over}, 1);
        return;
      end
      if (!issue_valid) begin
        chk(1'b0, "R2 issue missing", 0, 1);
        return;
      end
      s = 1 - last_side;
      exp_pc = mq[s][hd[s]];
      hd[s] = (hd[s] + 1) % D;
      cnt[s]--;
      if (step < 2)
        chk(issue_side == s[0] && issue_pc == AW'(exp_pc), "R1 first issues",
            issue_pc, exp_pc);
      chk(issue_side == s[0], "R2 side order", issue_side, s);
      chk(issue_pc == AW'(exp_pc), "R3 head pc", issue_pc, exp_pc);
      chk(issue_pc < AW'(CS), "R8 pc range", issue_pc, CS);
      chk(q_full == {cnt[1] == D, cnt[0] == D} && q_empty == {cnt[1] == 0, cnt[0] == 0},
          "R9 flags", {q_full, q_empty}, {cnt[1] == D, cnt[0] == D, cnt[1] == 0, cnt[0] == 0});
      r = int'($urandom % 4);
      for (int h = 0; h < r; h++) begin
        @(negedge clk);
        chk(issue_valid && issue_pc == AW'(exp_pc), "R11 hold", issue_pc, exp_pc);
      end
      nv = int'($urandom % (1 << AW));
      sv = int'($urandom % (1 << AW));
      if (mode == 1) begin
        dn = 1'b0; ds = 1'b0;
      end else if (mode == 2) begin
        dn = 1'b1; ds = 1'b1;
      end else begin
        dn = ($urandom % 100) >= 8;
        ds = ($urandom % 100) < 35;
      end
      done = 1'b1; push_next = dn; push_spawn = ds;
      next_pc = AW'(nv); spawn_pc = AW'(sv);
      @(negedge clk);
      done = 1'b0; push_next = 1'b0; push_spawn = 1'b0;
      // R4 R6: next first, then spawn; R7: spawn dropped when full; R5: kill
      if (dn) mpush(s, wrapv(nv));
      if (ds && cnt[s] < D) mpush(s, wrapv(sv));
      last_side = s;
      if (cnt[s] == 0) begin
        over_exp = 1'b1;
        lose_exp = s;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    play(8100, 8191, 0);   // R8 entries above core size
    play(5, 10, 1);        // R5 kill at once, side 0 loses
    play(0, 7999, 2);      // R6 R7 continuous spawning into a full queue
    for (int g = 0; g < 10; g++)
      play(int'($urandom % (1 << AW)), int'($urandom % (1 << AW)), 0);
    finish_run();
  end
endmodule